// File: doc/BRIEF.md
# UART Receive Byte Buffer with Status Words

This block sits on the receive side of a memory-mapped UART. It sits between the bit-level deserialiser and the register bus. Bytes and break indications from the receiver go into a ring buffer with a parameterised depth. Bus reads of the receive data register take them out in arrival order. The bus sees four things:

- a packed occupancy/full word,
- a sticky error word that clears when read,
- a data-ready flag,
- a one-cycle error event pulse that feeds the interrupt logic elsewhere.

A three-bit control word works as follows:

- Bit 0 selects buffered mode.
- Bit 1 requests a one-shot flush of the receive buffer.
- Bit 2 requests a one-shot flush of the transmit side. The transmit flush is exported as a pulse.

With buffered mode off, the block keeps one holding register and a valid flag in place of the ring.

Top module: `uart_rx_fifo_stat`

## Requirements
- R1: Control write bit 0 sets buffered mode, and `ctl_rdata` bit 0 returns it. Bit 1 empties the receive ring at the edge of the write. Bit 2 makes `tx_flush` high for exactly the one cycle after the write. Bits 1 and 2 always read back as 0.
- R2: `fifo_stat` bits [7:0] give the number of stored bytes and bit 8 is the full flag. While bit 8 is 1, bits [7:0] read as 0.
- R3: In buffered mode bytes come out in arrival order. Both ring pointers wrap modulo DEPTH, including for a DEPTH that is not a power of two.
- R4: In buffered mode, a byte that arrives while the ring is full and no read happens in that cycle is dropped. The stored bytes stay as they were, error word bit 0 (overrun) is set, and `err_evt` is high in the next cycle.
- R5: In buffered mode, a read of an empty ring returns 0x00 and makes `err_evt` high in the next cycle. Neither pointer moves, so the next byte pushed is the next byte read.
- R6: In buffered mode, `data_rdy` goes to 1 once a byte is stored. It goes to 0 when a read removes the last byte.
- R7: With buffered mode off, an arriving byte loads the holding register and sets `data_rdy`. A read returns that byte and clears `data_rdy`. A byte that arrives while `data_rdy` is 1 and no read happens replaces the old byte and sets error word bit 0.
- R8: A break indication acts as the arrival of a 0x00 byte, into the ring or the holding register. It sets error word bit 3.
- R9: `rx_par_err` and `rx_frm_err`, sampled with `rx_valid`, set error word bits 1 and 2. An `err_rd` strobe clears the error word at the next edge, but a bit set in the same cycle survives.
- R10: In buffered mode, a byte arrival and a read in the same cycle on a non-empty ring leave `fifo_stat` unchanged. This holds even when the ring is full, and no overrun is raised in that case.
- R11: A receive flush in the same cycle as a byte arrival drops that byte. The ring is empty afterwards.
- R12: After reset:
  - `fifo_stat`, `err_word`, `data_rdy`, `err_evt` and `tx_flush` are 0.
  - Buffered mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control bits: 0 mode, 1 receive flush, 2 transmit flush |
| ctl_rdata | output | 3 | Control readback, flush bits read 0 |
| tx_flush | output | 1 | One-cycle transmit flush pulse |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DW | Received byte |
| rx_par_err | input | 1 | Parity error flag for the byte |
| rx_frm_err | input | 1 | Framing error flag for the byte |
| rx_brk | input | 1 | Break indication |
| rd_req | input | 1 | Receive data register read strobe |
| rd_data | output | DW | Receive data returned in the read cycle |
| data_rdy | output | 1 | Receive data available |
| fifo_stat | output | 9 | Bit 8 full, bits [7:0] occupancy |
| err_rd | input | 1 | Error word read strobe (clears the word) |
| err_word | output | 4 | Bit 0 overrun, 1 parity, 2 frame, 3 break |
| err_evt | output | 1 | Error event pulse, overrun or empty read |

## Verification
The bench builds the block with DEPTH set to 5. This makes the full flag reachable after five pushes. It also makes the pointer wrap a non-power-of-two modulus, where a wrap that relies on a dropped carry bit would go wrong. Occupancy values are then small enough that every step from empty to full can be checked. These include the full state reading zero occupancy, and a same-cycle push and read on a full ring.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int unsigned CTL_EN_BIT    = 0;
  localparam int unsigned CTL_RXCLR_BIT = 1;
  localparam int unsigned CTL_TXCLR_BIT = 2;
  localparam int unsigned OCC_FW        = 8;

  // error word layout, bit 0 at the right
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } err_word_t;
endpackage

// File: rtl/rxbuf_ctl.sv
module rxbuf_ctl
  import rxbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wdata,
  output logic       fifo_en,
  output logic       rx_clr,
  output logic       tx_clr_pulse
);
  logic en_q, en_d;
  logic txp_q, txp_d;

  always_comb begin
    en_d  = en_q;
    if (wr_en) en_d = wdata[CTL_EN_BIT];
    txp_d = wr_en & wdata[CTL_TXCLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      txp_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      txp_q <= txp_d;
    end
  end

  assign fifo_en      = en_q;
  assign rx_clr       = wr_en & wdata[CTL_RXCLR_BIT];
  assign tx_clr_pulse = txp_q;
endmodule

// File: rtl/rxbuf_ring.sv
module rxbuf_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                din,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         empty,
  output logic                         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST    = PW'(DEPTH-1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULLCNT);
  assign do_pop  = pop & ~empty & ~clr;
  assign do_push = push & ~clr & (~full | do_pop);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = step(wp_q);
      if (do_pop)  rp_d = step(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign head = mem[rp_q];
  assign cnt  = cnt_q;
endmodule

// File: rtl/rxbuf_err.sv
module rxbuf_err #(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_clr,
  input  logic [NB-1:0] set,
  output logic [NB-1:0] word
);
  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic q, d;
    always_comb d = (q & ~rd_clr) | set[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign word[i] = q;
  end
endmodule

// File: rtl/uart_rx_fifo_stat.sv
module uart_rx_fifo_stat
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [2:0]    ctl_wdata,
  output logic [2:0]    ctl_rdata,
  output logic          tx_flush,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          rx_brk,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          data_rdy,
  output logic [8:0]    fifo_stat,
  input  logic          err_rd,
  output logic [3:0]    err_word,
  output logic          err_evt
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic          fifo_en, rx_clr;
  logic          arrive;
  logic [DW-1:0] arrive_byte;
  logic          f_push, f_pop;
  logic [DW-1:0] head;
  logic [CW-1:0] cnt;
  logic          empty, full;
  logic          ovf_fifo, ovf_hold, empty_rd, h_load, h_rd;
  logic [DW-1:0] hold_q, hold_d;
  logic          hvld_q, hvld_d;
  logic          evt_q, evt_d;
  err_word_t     err_set;

  rxbuf_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (ctl_wr),
    .wdata        (ctl_wdata),
    .fifo_en      (fifo_en),
    .rx_clr       (rx_clr),
    .tx_clr_pulse (tx_flush)
  );

  assign arrive      = rx_valid | rx_brk;
  assign arrive_byte = rx_brk ? '0 : rx_data;
  assign f_push      = fifo_en & arrive;
  assign f_pop       = fifo_en & rd_req;

  rxbuf_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .push  (f_push),
    .pop   (f_pop),
    .din   (arrive_byte),
    .head  (head),
    .cnt   (cnt),
    .empty (empty),
    .full  (full)
  );

  // error sources
  assign ovf_fifo = f_push & full & ~rd_req & ~rx_clr;
  assign empty_rd = f_pop & empty;
  assign h_load   = ~fifo_en & arrive;
  assign h_rd     = ~fifo_en & rd_req;
  assign ovf_hold = h_load & hvld_q & ~rd_req;

  always_comb begin
    err_set     = '0;
    err_set.ovr = ovf_fifo | ovf_hold;
    err_set.par = rx_valid & rx_par_err;
    err_set.frm = rx_valid & rx_frm_err;
    err_set.brk = rx_brk;
  end

  rxbuf_err #(.NB(4)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_clr (err_rd),
    .set    (err_set),
    .word   (err_word)
  );

  // holding register path and event pulse
  always_comb begin
    hold_d = hold_q;
    hvld_d = hvld_q;
    if (h_load) begin
      hold_d = arrive_byte;
      hvld_d = 1'b1;
    end else if (h_rd) begin
      hvld_d = 1'b0;
    end
    evt_d = ovf_fifo | empty_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hvld_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      hvld_q <= hvld_d;
      evt_q  <= evt_d;
    end
  end

  assign err_evt   = evt_q;
  assign rd_data   = fifo_en ? (empty ? '0 : head) : hold_q;
  assign data_rdy  = fifo_en ? ~empty : hvld_q;
  assign fifo_stat = full ? {1'b1, {OCC_FW{1'b0}}} : {1'b0, OCC_FW'(cnt)};
  assign ctl_rdata = {2'b00, fifo_en};
endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ctl_rdata,
  input logic       ctl_wr,
  input logic [2:0] ctl_wdata,
  input logic       tx_flush,
  input logic       rx_valid,
  input logic       rx_brk,
  input logic       rd_req,
  input logic       err_rd,
  input logic [7:0] rd_data,
  input logic       data_rdy,
  input logic [8:0] fifo_stat,
  input logic [3:0] err_word,
  input logic       err_evt
);
  logic fen, arr, stat_empty;
  assign fen        = ctl_rdata[0];
  assign arr        = rx_valid | rx_brk;
  assign stat_empty = (fifo_stat == 9'd0);

  a_r2_full_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_stat[8] |-> fifo_stat[7:0] == 8'd0);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_stat[8] |-> 32'(fifo_stat[7:0]) < DEPTH);
  a_r1_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1]) |=> stat_empty);
  a_r1_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[2]) |=> tx_flush);
  a_r1_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && ctl_wdata[2]) |=> !tx_flush);
  a_r4_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && !ctl_wr && fifo_stat[8] && arr && !rd_req) |=>
      (err_evt && err_word[0] && fifo_stat[8]));
  a_r5_empty_data: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && rd_req && stat_empty) |-> rd_data == 8'd0);
  a_r5_empty_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && rd_req && stat_empty) |=> err_evt);
  a_r6_last_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && !ctl_wr && rd_req && !arr && fifo_stat == 9'd1) |=> !data_rdy);
  a_r7_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!fen && !ctl_wr && rx_valid) |=> data_rdy);
  a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && !rx_valid && !rx_brk) |=> err_word == 4'd0);
  a_r10_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && !ctl_wr && arr && rd_req && !stat_empty) |=> $stable(fifo_stat));
  a_r12_evt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!arr && !rd_req) |=> !err_evt);
endmodule

bind uart_rx_fifo_stat rxbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_rdata (ctl_rdata),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .tx_flush  (tx_flush),
  .rx_valid  (rx_valid),
  .rx_brk    (rx_brk),
  .rd_req    (rd_req),
  .err_rd    (err_rd),
  .rd_data   (rd_data),
  .data_rdy  (data_rdy),
  .fifo_stat (fifo_stat),
  .err_word  (err_word),
  .err_evt   (err_evt)
);

// File: tb/sim_uart_rx_fifo_stat.sv
`timescale 1ns/1ps
module sim_uart_rx_fifo_stat;
  localparam int unsigned DEPTH = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [2:0] ctl_wdata;
  logic [2:0] ctl_rdata;
  logic       tx_flush;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_par_err, rx_frm_err, rx_brk;
  logic       rd_req;
  logic [7:0] rd_data;
  logic       data_rdy;
  logic [8:0] fifo_stat;
  logic       err_rd;
  logic [3:0] err_word;
  logic       err_evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_fifo_stat #(.DEPTH(DEPTH), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .tx_flush(tx_flush), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .rx_brk(rx_brk), .rd_req(rd_req), .rd_data(rd_data), .data_rdy(data_rdy),
    .fifo_stat(fifo_stat), .err_rd(err_rd), .err_word(err_word), .err_evt(err_evt)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    ctl_wr = 0; ctl_wdata = 0; rx_valid = 0; rx_data = 0;
    rx_par_err = 0; rx_frm_err = 0; rx_brk = 0; rd_req = 0; err_rd = 0;
  endtask

  // one bus/receiver cycle; rdv/erv are the values seen during the cycle
  task automatic cyc(input logic v, input logic [7:0] d, input logic p, input logic f,
                     input logic b, input logic rd, input logic er,
                     input logic cw, input logic [2:0] cwd,
                     output logic [7:0] rdv, output logic [3:0] erv);
    @(negedge clk);
    rx_valid = v; rx_data = d; rx_par_err = p; rx_frm_err = f; rx_brk = b;
    rd_req = rd; err_rd = er; ctl_wr = cw; ctl_wdata = cwd;
    #1;
    rdv = rd_data;
    erv = err_word;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic push(input logic [7:0] d);
    logic [7:0] r; logic [3:0] e;
    cyc(1, d, 0, 0, 0, 0, 0, 0, 3'b000, r, e);
  endtask

  task automatic pop(output logic [7:0] r);
    logic [3:0] e;
    cyc(0, 8'h00, 0, 0, 0, 1, 0, 0, 3'b000, r, e);
  endtask

  task automatic wctl(input logic [2:0] v);
    logic [7:0] r; logic [3:0] e;
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 1, v, r, e);
  endtask

  task automatic rderr(output logic [3:0] e);
    logic [7:0] r;
    cyc(0, 8'h00, 0, 0, 0, 0, 1, 0, 3'b000, r, e);
  endtask

  task automatic nop();
    logic [7:0] r; logic [3:0] e;
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, r, e);
  endtask

  task automatic t_reset();
    chk("R12 stat", 32'(fifo_stat), 0);
    chk("R12 rdy", 32'(data_rdy), 0);
    chk("R12 err", 32'(err_word), 0);
    chk("R12 ctl", 32'(ctl_rdata), 0);
    chk("R12 evt", 32'(err_evt), 0);
    chk("R12 txf", 32'(tx_flush), 0);
  endtask

  task automatic t_ctl();
    wctl(3'b111);
    chk("R1 ctl readback", 32'(ctl_rdata), 32'h1);
    chk("R1 tx pulse", 32'(tx_flush), 1);
    nop();
    chk("R1 tx pulse end", 32'(tx_flush), 0);
  endtask

  task automatic t_order();
    logic [7:0] r;
    push(8'h11); push(8'h22); push(8'h33);
    chk("R2 count 3", 32'(fifo_stat), 3);
    pop(r); chk("R3 order 0", 32'(r), 32'h11);
    pop(r); chk("R3 order 1", 32'(r), 32'h22);
    pop(r); chk("R3 order 2", 32'(r), 32'h33);
    for (int i = 0; i < 5; i++) push(8'hA1 + 8'(i));
    chk("R2 full reads zero count", 32'(fifo_stat), 32'h100);
    for (int i = 0; i < 5; i++) begin
      pop(r); chk("R3 wrap order", 32'(r), 32'hA1 + i);
    end
    chk("R2 empty", 32'(fifo_stat), 0);
  endtask

  task automatic t_overrun();
    logic [7:0] r; logic [3:0] e;
    rderr(e);
    for (int i = 0; i < 5; i++) push(8'hB1 + 8'(i));
    push(8'hEE);
    chk("R4 evt", 32'(err_evt), 1);
    chk("R4 ovr bit", 32'(err_word), 1);
    chk("R4 still full", 32'(fifo_stat), 32'h100);
    nop();
    chk("R4 evt one cycle", 32'(err_evt), 0);
    for (int i = 0; i < 5; i++) begin
      pop(r); chk("R4 content kept", 32'(r), 32'hB1 + i);
    end
  endtask

  task automatic t_empty();
    logic [7:0] r; logic [3:0] e;
    rderr(e);
    pop(r);
    chk("R5 empty data", 32'(r), 0);
    chk("R5 evt", 32'(err_evt), 1);
    chk("R5 count", 32'(fifo_stat), 0);
    push(8'h3C);
    chk("R5 count after push", 32'(fifo_stat), 1);
    pop(r);
    chk("R5 pointers held", 32'(r), 32'h3C);
  endtask

  task automatic t_rdy();
    logic [7:0] r;
    push(8'h01);
    chk("R6 rdy set", 32'(data_rdy), 1);
    push(8'h02);
    pop(r);
    chk("R6 rdy kept", 32'(data_rdy), 1);
    pop(r);
    chk("R6 rdy clear", 32'(data_rdy), 0);
  endtask

  task automatic t_pushpop();
    logic [7:0] r; logic [3:0] e;
    rderr(e);
    push(8'h61); push(8'h62);
    cyc(1, 8'h63, 0, 0, 0, 1, 0, 0, 3'b000, r, e);
    chk("R10 head", 32'(r), 32'h61);
    chk("R10 count kept", 32'(fifo_stat), 2);
    push(8'h64); push(8'h65); push(8'h66);
    cyc(1, 8'h67, 0, 0, 0, 1, 0, 0, 3'b000, r, e);
    chk("R10 full head", 32'(r), 32'h62);
    chk("R10 full kept", 32'(fifo_stat), 32'h100);
    chk("R10 no evt", 32'(err_evt), 0);
    chk("R10 no ovr", 32'(err_word), 0);
    for (int i = 0; i < 5; i++) begin
      pop(r); chk("R10 order", 32'(r), 32'h63 + i);
    end
  endtask

  task automatic t_break();
    logic [7:0] r; logic [3:0] e;
    rderr(e);
    cyc(0, 8'hFF, 0, 0, 1, 0, 0, 0, 3'b000, r, e);
    chk("R8 count", 32'(fifo_stat), 1);
    chk("R8 brk bit", 32'(err_word), 32'h8);
    pop(r);
    chk("R8 zero byte", 32'(r), 0);
  endtask

  task automatic t_flags();
    logic [7:0] r; logic [3:0] e;
    rderr(e);
    cyc(1, 8'h5A, 1, 1, 0, 0, 0, 0, 3'b000, r, e);
    chk("R9 par frm", 32'(err_word), 32'h6);
    rderr(e);
    chk("R9 read value", 32'(e), 32'h6);
    chk("R9 cleared", 32'(err_word), 0);
    cyc(0, 8'h00, 0, 0, 1, 0, 1, 0, 3'b000, r, e);
    chk("R9 set wins", 32'(err_word), 32'h8);
    pop(r); pop(r);
    rderr(e);
  endtask

  task automatic t_flush();
    logic [7:0] r; logic [3:0] e;
    push(8'h71); push(8'h72); push(8'h73);
    cyc(1, 8'h74, 0, 0, 0, 0, 0, 1, 3'b011, r, e);
    chk("R11 flushed", 32'(fifo_stat), 0);
    chk("R11 rdy", 32'(data_rdy), 0);
    chk("R1 mode kept", 32'(ctl_rdata), 1);
    push(8'h75);
    chk("R11 count", 32'(fifo_stat), 1);
    pop(r);
    chk("R11 after flush", 32'(r), 32'h75);
  endtask

  task automatic t_hold();
    logic [7:0] r; logic [3:0] e;
    wctl(3'b000);
    chk("R7 mode off", 32'(ctl_rdata), 0);
    rderr(e);
    push(8'h55);
    chk("R7 rdy", 32'(data_rdy), 1);
    chk("R7 ring untouched", 32'(fifo_stat), 0);
    pop(r);
    chk("R7 data", 32'(r), 32'h55);
    chk("R7 rdy clear", 32'(data_rdy), 0);
    push(8'h11); push(8'h22);
    chk("R7 overwrite ovr", 32'(err_word), 1);
    pop(r);
    chk("R7 newest", 32'(r), 32'h22);
    cyc(0, 8'hFF, 0, 0, 1, 0, 0, 0, 3'b000, r, e);
    chk("R8 hold rdy", 32'(data_rdy), 1);
    pop(r);
    chk("R8 hold zero", 32'(r), 0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_order();
    t_overrun();
    t_empty();
    t_rdy();
    t_pushpop();
    t_break();
    t_flags();
    t_flush();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule